// File: doc/BRIEF.md
# Instruction Fetch Unit

This block is the fetch stage of a small non-pipelined 32-bit core. It holds the program counter in a register that is written from an incoming address when a load strobe is set. It reads a read-only instruction store at that address and registers the fetched word. In parallel it computes the address of the next sequential word and registers that too. The surrounding control logic feeds the next address (or a branch target computed elsewhere) back to the address input and pulses the load strobe one cycle before each fetch. The memory enable can also be tied high.

The instruction store is 4096 words of 32 bits and is selected by the word-index bits of the program counter. Its contents are computed from the word index and a seed parameter, so no memory file is needed. The store's synchronous clear acts only while its enable is high. The program-counter and next-address registers are cleared by reset whatever the enable does.

Top module: `ifetch_unit`

## Requirements
- R1: With `rst_n` low and `mem_en` high at a rising edge, `instr` and `npc` read 0 after that edge, and the PC is 0. The next enabled fetch with `pc_load` low returns word 0 and `npc` = 4.
- R2: When `pc_load` is high at a rising edge, `pc_in` is written into the PC at that edge. The fetch at the following enabled edge uses that address.
- R3: When `pc_load` is low, the PC keeps its value, so repeated enabled fetches return the same word and the same `npc`.
- R4: The store is indexed by PC bits [13:2]; bits [1:0] and bits [31:14] have no effect on the word read. The word at index i is (i × 0x9E3779B1) XOR SEED, modulo 2^32, with SEED = 0x13579BDF by default.
- R5: `instr` is registered. At each rising edge with `mem_en` high and `rst_n` high, it takes the store word for the PC value held before that edge.
- R6: At the same edge, `npc` takes that PC value plus 4, modulo 2^32.
- R7: With `mem_en` low and `rst_n` high, `instr` and `npc` keep their values across the edge.
- R8: With `rst_n` low and `mem_en` low, `instr` keeps its value while `npc` and the PC are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_in | input | 32 | Address to load into the PC |
| pc_load | input | 1 | Writes `pc_in` into the PC at the edge |
| mem_en | input | 1 | Enables the fetch (read, next-address update, store clear) |
| instr | output | 32 | Registered instruction word |
| npc | output | 32 | Registered PC + 4 |

## Verification
A wrong PC shows up one enabled edge later, as an `instr` word and an `npc` that do not belong to the expected address. The `npc` port carries the full PC value and so reveals errors in the upper bits that the store ignores. A wrong store index or offset shows up as a wrong `instr` in the same cycle. A bad enable or reset gating shows up at the first edge where `mem_en` or `rst_n` is low, as an output that changed when it should have held or held when it should have cleared.

// File: rtl/ifu_pkg.sv
// Package for the fetch unit: shared widths and the instruction-store
// content function. Assumes a 32-bit word and a store of at most 2^31 words.
package ifu_pkg;

    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] MIX_K = 32'h9E3779B1;

    typedef logic [WORD_W-1:0] word_t;

    // Word held at a store index: index times a mixing constant, xor seed.
    function automatic word_t store_word(input word_t idx, input word_t seed);
        return (idx * MIX_K) ^ seed;
    endfunction

endpackage

// File: rtl/ifu_pc_reg.sv
// Program-counter register. Loads the incoming address when the load strobe
// is high and otherwise holds. Synchronous active-low reset clears it.
module ifu_pc_reg #(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] pc_in,
    output logic [XLEN-1:0] pc_q
);

    // PC update: clear on reset, load on strobe, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (load)
            pc_q <= pc_in;
    end

    AST_PC_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pc_q == $past(pc_in))); // R2

    AST_PC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(pc_q)); // R3

endmodule

// File: rtl/ifu_npc.sv
// Next-address register. On an enabled edge stores PC plus one word.
// The reset clears it whatever the enable does.
module ifu_npc #(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] npc_q
);

    localparam int unsigned STEP = XLEN / 8;
    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    // Next-address update: clear on reset, PC + step when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            npc_q <= '0;
        else if (en)
            npc_q <= pc + STEP_V;
    end

    AST_NPC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(npc_q)); // R7

endmodule

// File: rtl/ifu_rom.sv
// Read-only instruction store with a registered output. Contents are
// computed from the index. The synchronous clear acts only while enabled.
// With the enable low the output register holds.
module ifu_rom #(
    parameter int unsigned AW   = 12,
    parameter logic [31:0] SEED = 32'h13579BDF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] idx,
    output logic [31:0]   data_q
);

    import ifu_pkg::*;

    word_t rd_word;

    // Combinational lookup of the selected word.
    always_comb rd_word = store_word(word_t'(idx), SEED);

    // Output register: clear or capture only while enabled.
    always_ff @(posedge clk) begin
        if (en) begin
            if (!rst_n)
                data_q <= '0;
            else
                data_q <= rd_word;
        end
    end

    AST_IR_HOLDS: assert property (@(posedge clk)
        !en |=> $stable(data_q)); // R8

    AST_IR_CLEARS: assert property (@(posedge clk)
        (!rst_n && en) |=> (data_q == '0)); // R1

endmodule

// File: rtl/ifetch_unit.sv
// Fetch stage top. Joins the PC register, the next-address register and the
// instruction store. The store is indexed by the word-index bits of the PC.
// The read and the next-address update happen at the same enabled edge.
module ifetch_unit #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned DEPTH = 4096,
    parameter logic [31:0] SEED  = 32'h13579BDF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] pc_in,
    input  logic        pc_load,
    input  logic        mem_en,
    output logic [31:0] instr,
    output logic [31:0] npc
);

    import ifu_pkg::*;

    localparam int unsigned AW  = $clog2(DEPTH);
    localparam int unsigned OFS = $clog2(XLEN / 8);

    logic [XLEN-1:0] pc_q;
    logic [AW-1:0]   rom_idx;

    // Word index taken from the PC; byte offset and upper bits unused.
    always_comb rom_idx = pc_q[OFS +: AW];

    ifu_pc_reg #(.XLEN(XLEN)) i_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pc_load),
        .pc_in (pc_in),
        .pc_q  (pc_q)
    );

    ifu_npc #(.XLEN(XLEN)) i_npc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mem_en),
        .pc    (pc_q),
        .npc_q (npc)
    );

    ifu_rom #(.AW(AW), .SEED(SEED)) i_rom (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (mem_en),
        .idx    (rom_idx),
        .data_q (instr)
    );

    AST_FETCH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> (instr == store_word(word_t'($past(rom_idx)), SEED))); // R5

    AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> (npc == $past(pc_q) + 32'd4)); // R6

    AST_NPC_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (npc == '0)); // R8

endmodule

// File: tb/test_ifetch_unit.sv
module test_ifetch_unit;

    localparam logic [31:0] SEED = 32'h13579BDF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_in = '0;
    logic        pc_load = 1'b0;
    logic        mem_en = 1'b1;
    logic [31:0] instr, npc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_pc = '0, m_ir = '0, m_npc = '0;

    always #2.5 clk = ~clk;

    ifetch_unit #(.SEED(SEED)) i_ifetch_unit (
        .clk(clk), .rst_n(rst_n), .pc_in(pc_in), .pc_load(pc_load),
        .mem_en(mem_en), .instr(instr), .npc(npc)
    );

    // Store content as the requirement states it: index bits [13:2].
    function automatic logic [31:0] exp_word(input logic [31:0] a);
        logic [31:0] i;
        i = {20'd0, a[13:2]};
        return (i * 32'h9E3779B1) ^ SEED;
    endfunction

    localparam int NV = 8;
    localparam logic [31:0] VEC_PC [NV] = '{
        32'h0000_0000, 32'h0000_0004, 32'h0000_1003, 32'h0000_3FFC,
        32'h0000_4000, 32'hABCD_0010, 32'hFFFF_FFFC, 32'h0000_0AA8 };
    localparam logic [31:0] VEC_NPC [NV] = '{
        32'h0000_0004, 32'h0000_0008, 32'h0000_1007, 32'h0000_4000,
        32'h0000_4004, 32'hABCD_0014, 32'h0000_0000, 32'h0000_0AAC };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One edge: update the model from the requirements, then sample.
    task automatic tick(input string tag);
        logic [31:0] old_pc;
        old_pc = m_pc;
        if (!rst_n) begin
            m_pc = '0; m_npc = '0;
            if (mem_en) m_ir = '0;
        end else begin
            if (pc_load) m_pc = pc_in;
            if (mem_en) begin
                m_ir = exp_word(old_pc);
                m_npc = old_pc + 32'd4;
            end
        end
        @(posedge clk); #1;
        chk({tag, " instr"}, instr, m_ir);
        chk({tag, " npc"}, npc, m_npc);
    endtask

    initial begin
        #1;
        rst_n = 1'b0; mem_en = 1'b1;
        tick("R1 reset");
        rst_n = 1'b1;
        tick("R1 word0");
        chk("R1 npc4", npc, 32'd4);
        chk("R1 word0 value", instr, exp_word(32'd0));

        // Vector table: load, then fetch at the loaded address.
        for (int k = 0; k < NV; k++) begin
            pc_in = VEC_PC[k]; pc_load = 1'b1;
            tick("R2 load");
            pc_load = 1'b0; pc_in = 32'h5555_5555;
            tick("R5 fetch");
            chk("R6 table npc", npc, VEC_NPC[k]);
            chk("R4 table word", instr, exp_word(VEC_PC[k]));
        end

        // Byte-offset and upper bits ignored: same word as 0x1000.
        pc_in = 32'h0000_1003; pc_load = 1'b1; tick("R2 load");
        pc_load = 1'b0; tick("R4 fetch");
        chk("R4 offset ignored", instr, exp_word(32'h0000_1000));
        pc_in = 32'h7FFF_0008; pc_load = 1'b1; tick("R2 load");
        pc_load = 1'b0; tick("R4 fetch");
        chk("R4 high ignored", instr, exp_word(32'h0000_0008));

        // PC holds while load is low.
        tick("R3 hold");
        chk("R3 repeat npc", npc, 32'h7FFF_000C);
        tick("R3 hold2");

        // Enable low: outputs hold, PC still loads.
        pc_in = 32'h0000_0100; pc_load = 1'b1; mem_en = 1'b0;
        tick("R7 hold");
        pc_load = 1'b0;
        tick("R7 hold2");
        chk("R7 npc held", npc, 32'h7FFF_000C);
        mem_en = 1'b1;
        tick("R5 after en");
        chk("R5 loaded while off", instr, exp_word(32'h0000_0100));

        // Reset with enable low: instr kept, npc cleared.
        rst_n = 1'b0; mem_en = 1'b0;
        tick("R8 reset off");
        chk("R8 instr kept", instr, exp_word(32'h0000_0100));
        chk("R8 npc zero", npc, 32'd0);
        rst_n = 1'b1; mem_en = 1'b1;
        tick("R8 pc cleared");
        chk("R8 word0", instr, exp_word(32'd0));

        // Sequential walk with npc fed back as the next address.
        for (int k = 0; k < 6; k++) begin
            pc_in = npc; pc_load = 1'b1;
            tick("R2 walk load");
            pc_load = 1'b0;
            tick("R6 walk fetch");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog act=running exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule